// File: doc/BRIEF.md
# Sampled LFSR Random-Number Recorder

This block produces a stream of 8-bit pseudorandom values from a maximal-length linear feedback shift register and records a snapshot of that stream into a small on-chip memory at a fixed interval. The register steps once per clock. Its starting point is chosen by a priority encoder over an external request vector, so the sequence phase depends on which request line is the highest active one when the load strobe is given.

A free-running 5-bit interval counter raises a sample strobe once every 32 cycles. On each strobe the value currently held by the register is written into a 16-entry memory at a write pointer that advances and wraps. A one-cycle valid pulse follows each write. The memory is read through a synchronous port with one cycle of latency, so a consumer can collect the recorded samples at any time.

Top module: `lfsr_sample_recorder`

## Requirements
- R1: With load asserted, the seed is one plus the index of the highest set bit of the request vector (bit 7 wins over every lower bit); with no bit set the seed is 8'h01.
- R2: A load strobe sampled at a rising edge makes the random output equal the seed after that edge and restarts the interval count at 0.
- R3: Without load the register advances each cycle as next = {q[6:0], q[7]^q[5]^q[4]^q[3]}; it never holds zero and returns to its starting value after exactly 255 steps.
- R4: A sample is written when the interval count reaches 31, i.e. the value shown on the random output 31 steps after a load is the first one recorded, and every 32 cycles after that.
- R5: The sample-valid output is high for exactly one cycle, the cycle after each memory write, and low otherwise.
- R6: The write address is 0 after reset, advances by one per sample and wraps from 15 to 0, so the 17th sample overwrites entry 0.
- R7: Read data shows the entry addressed in the previous cycle; a read of the entry being written on that same edge returns its former contents.
- R8: A load in the cycle where the count is 31 takes priority: no write occurs, no valid pulse follows and the write address does not move.
- R9: Reset is asynchronous and active low: it forces the random output to 8'h01, the valid output low, and the count and write address to 0; after release, the first edge that changes state is the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| seed_req_i | input | 8 | Request vector for the seed priority encoder |
| seed_load_i | input | 1 | Load the encoded seed and restart the interval count |
| rd_addr_i | input | 4 | Memory read address |
| rnd_o | output | 8 | Current register value |
| sample_valid_o | output | 1 | One-cycle pulse after each sample write |
| rd_data_o | output | 8 | Memory read data, one cycle after the address |

## Verification
The encoder is driven with an empty vector, single lines at the low and high ends and in the middle, and vectors with several lines set, which separates a correct priority order from an inverted one and from a plain count of active lines. The stepping is followed for a full 255-cycle period from seed 8'h01, which tells the right tap set from any other, and memory is filled past one wrap while reading every address, which separates address wrap, read latency and old-data-on-collision behaviour. A load placed exactly on the sampling cycle and a reset asserted mid-cycle exercise the priority and asynchronous paths.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int unsigned RND_W = 8;
  // x^8 + x^6 + x^5 + x^4 + 1 : state bits 7, 5, 4, 3 feed the new bit 0
  localparam logic [RND_W-1:0] TAP_MASK   = 8'b1011_1000;
  localparam logic [RND_W-1:0] RESET_SEED = 8'h01;
  localparam int unsigned CNT_W   = 5;
  localparam int unsigned DEPTH   = 16;
  localparam int unsigned ADDR_W  = $clog2(DEPTH);
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/lsr_reset_sync.sv
module lsr_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/lsr_seed_enc.sv
module lsr_seed_enc #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] seed_o
);
  logic [W-1:0] idx;
  logic         any;

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (req_i[i]) begin
        idx = W'(i);
        any = 1'b1;
      end
    end
    seed_o = any ? W'(idx + 1'b1) : W'(1);
  end
endmodule

// File: rtl/lsr_lfsr.sv
module lsr_lfsr #(
  parameter int unsigned     W        = 8,
  parameter logic [W-1:0]    TAPS     = 8'b1011_1000,
  parameter logic [W-1:0]    INIT_VAL = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         fb;

  always_comb begin
    fb      = ^(state_q & TAPS);
    state_d = load_i ? seed_i : {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= INIT_VAL;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R2
  lfsr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> state_q == $past(seed_i));
endmodule

// File: rtl/lsr_interval_cnt.sv
module lsr_interval_cnt #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         strobe_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = load_i ? load_val_i : W'(cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign strobe_o = &cnt_q;

  // R4
  cnt_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> cnt_q == W'($past(cnt_q) + 1'b1));
  // R2
  cnt_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/lsr_sample_ram.sv
module lsr_sample_ram #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q;
  logic [AW-1:0] wptr_d;
  logic [DW-1:0] rd_q;

  always_comb begin
    wptr_d = wr_en_i ? AW'(wptr_q + 1'b1) : wptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wptr_q <= '0;
    else        wptr_q <= wptr_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wptr_q] <= wr_data_i;
    rd_q <= mem[rd_addr_i];
  end

  assign rd_data_o = rd_q;

  // R6
  ram_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> wptr_q == AW'($past(wptr_q) + 1'b1));
  // R8
  ram_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(wptr_q));
endmodule

// File: rtl/lfsr_sample_recorder.sv
module lfsr_sample_recorder
  import lsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RND_W-1:0]  seed_req_i,
  input  logic              seed_load_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [RND_W-1:0]  rnd_o,
  output logic              sample_valid_o,
  output logic [RND_W-1:0]  rd_data_o
);
  logic             rst_sync_n;
  logic [RND_W-1:0] seed_w;
  logic [RND_W-1:0] rnd_w;
  logic             strobe_w;
  logic             wr_en;
  logic             valid_q;

  lsr_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n));

  lsr_seed_enc #(.W(RND_W)) u_enc (.req_i(seed_req_i), .seed_o(seed_w));

  lsr_lfsr #(.W(RND_W), .TAPS(TAP_MASK), .INIT_VAL(RESET_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_sync_n), .load_i(seed_load_i),
    .seed_i(seed_w), .state_o(rnd_w));

  lsr_interval_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .load_i(seed_load_i),
    .load_val_i('0), .strobe_o(strobe_w));

  // load has priority over the sampling strobe
  assign wr_en = strobe_w & ~seed_load_i;

  lsr_sample_ram #(.DW(RND_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_sync_n), .wr_en_i(wr_en), .wr_data_i(rnd_w),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) valid_q <= 1'b0;
    else             valid_q <= wr_en;
  end

  assign rnd_o          = rnd_w;
  assign sample_valid_o = valid_q;

  // R1
  enc_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seed_w != '0);
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sample_valid_o |=> !sample_valid_o);
  // R8
  load_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seed_load_i |=> !sample_valid_o);
endmodule

// File: tb/test_lfsr_sample_recorder.sv
module test_lfsr_sample_recorder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] seed_req;
  logic       seed_load;
  logic [3:0] rd_addr;
  logic [7:0] rnd;
  logic       valid;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  lfsr_sample_recorder i_lfsr_sample_recorder (
    .clk(clk), .rst_n(rst_n), .seed_req_i(seed_req), .seed_load_i(seed_load),
    .rd_addr_i(rd_addr), .rnd_o(rnd), .sample_valid_o(valid), .rd_data_o(rd_data));

  // request vector (upper byte) -> expected seed (lower byte)
  localparam logic [15:0] SEED_TAB [8] = '{16'h0001, 16'h0101, 16'h8008, 16'hFF08,
                                            16'h1405, 16'h0202, 16'h4007, 16'h2006};

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_lfsr;
  logic [4:0] m_cnt;
  logic [3:0] m_wptr;
  logic       m_valid;
  logic [7:0] m_mem [16];
  logic       m_known [16];
  int         n_samples;

  function automatic logic [7:0] step(input logic [7:0] q);
    return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
  endfunction

  function automatic logic [7:0] seed_of(input logic [7:0] r);
    for (int i = 7; i >= 0; i--) if (r[i]) return 8'(i + 1);
    return 8'h01;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge; applies inputs, advances the model over one rising edge
  task automatic tick(input logic ld, input logic [7:0] req, input logic [3:0] ra);
    logic       rd_kn;
    logic [7:0] rd_exp;
    seed_load = ld; seed_req = req; rd_addr = ra;
    rd_kn = m_known[ra]; rd_exp = m_mem[ra];
    if (ld) begin
      m_lfsr = seed_of(req); m_cnt = '0; m_valid = 1'b0;
    end else begin
      m_valid = (m_cnt == 5'd31);
      if (m_valid) begin
        m_mem[m_wptr] = m_lfsr; m_known[m_wptr] = 1'b1;
        m_wptr = m_wptr + 1'b1; n_samples++;
      end
      m_lfsr = step(m_lfsr); m_cnt = m_cnt + 1'b1;
    end
    @(negedge clk);
    chk(ld ? "R2" : "R3", rnd, m_lfsr);
    chk(m_valid ? "R4/R5" : "R5", valid, m_valid);
    if (rd_kn) chk("R7", rd_data, rd_exp);
  endtask

  task automatic release_reset();
    m_lfsr = 8'h01; m_cnt = '0; m_wptr = '0; m_valid = 1'b0;
    seed_load = 1'b0;
    @(negedge clk);
    chk("R9", rnd, 8'h01);
    chk("R9", valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk); chk("R9", rnd, 8'h01);
    @(negedge clk); chk("R9", rnd, 8'h01);
  endtask

  initial begin
    logic [7:0] v;
    int         len;
    logic       zero_seen;
    rst_n = 1'b0; seed_req = '0; seed_load = 1'b0; rd_addr = '0;
    n_samples = 0;
    for (int i = 0; i < 16; i++) begin m_known[i] = 1'b0; m_mem[i] = '0; end
    repeat (3) @(negedge clk);
    release_reset();
    // first active edge after release is the third one
    tick(1'b0, 8'h00, 4'd0);
    chk("R9", rnd, 8'h02);

    // table of request vectors
    for (int k = 0; k < 8; k++) begin
      tick(1'b1, SEED_TAB[k][15:8], 4'd0);
      chk("R1", rnd, SEED_TAB[k][7:0]);
      for (int c = 0; c < 40; c++) tick(1'b0, 8'h00, 4'(c));
    end

    // fill past one wrap with reads on every address and at the write slot
    rst_n = 1'b0;
    release_reset();
    tick(1'b1, 8'h00, 4'd0);
    n_samples = 0;
    for (int c = 0; c < 18 * 32; c++)
      tick(1'b0, 8'h00, (m_cnt == 5'd31) ? m_wptr : 4'(c));
    chk("R6", n_samples, 18);
    tick(1'b0, 8'h00, 4'd0);
    tick(1'b0, 8'h00, 4'd0);
    chk("R6", rd_data, m_mem[0]);

    // load exactly on the sampling cycle
    while (m_cnt != 5'd31) tick(1'b0, 8'h00, 4'd0);
    v = m_wptr;
    tick(1'b1, 8'h80, 4'd0);
    tick(1'b0, 8'h00, 4'd0);
    chk("R8", valid, 1'b0);
    chk("R8", m_wptr, v);
    for (int c = 0; c < 40; c++) tick(1'b0, 8'h00, 4'(c));

    // full period from seed 01
    tick(1'b1, 8'h00, 4'd0);
    len = 0; zero_seen = 1'b0;
    do begin
      tick(1'b0, 8'h00, 4'd0);
      len++;
      if (rnd == 8'h00) zero_seen = 1'b1;
    end while (rnd != 8'h01 && len < 300);
    chk("R3", len, 255);
    chk("R3", zero_seen, 1'b0);

    // asynchronous reset in the middle of a cycle
    for (int c = 0; c < 5; c++) tick(1'b0, 8'h00, 4'd0);
    #1 rst_n = 1'b0;
    #1 chk("R9", rnd, 8'h01);
    chk("R9", valid, 1'b0);
    release_reset();
    for (int c = 0; c < 34; c++) tick(1'b0, 8'h00, 4'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule